// File: doc/BRIEF.md
# Jacobian Point Addition Sequencer

This block drives an external modular arithmetic unit through the full addition of two elliptic-curve points P and Q, both held in Jacobian form (X, Y, Z) in that unit's operand register file. It does no arithmetic of its own. It walks a fixed list of multiply, add and subtract micro-operations. Each one names two source registers and one destination register. The list leaves the sum R in the result registers.

On a start request the block latches two zero flags that the surrounding datapath supplies for Pz and Qz. The arithmetic list then always runs to its end. After it, and only when a flag was set, the block issues three copy operations that overwrite R with the operand that is not at infinity. The cases P = Q and P = −Q are not handled, because in the intended ladder use the two points always differ by the base point. Both operands at infinity is also outside the contract.

Commands leave on a valid/ready channel. A command stays valid with all fields unchanged until the unit raises ready, and the transfer happens on the edge where both are high. The block then waits for a one-cycle completion pulse from the unit before it presents the next command. This keeps every read-after-write dependency safe, whatever the unit's latency.

Top module: `ptadd_seq`

## Requirements
- R1: A start pulse while idle latches the Pz-zero and Qz-zero inputs. Changes on those inputs later in the run have no effect on the command stream or the result.
- R2: Register addresses are 0 to 8 for PX, PY, PZ, QX, QY, QZ, RX, RY, RZ, and 9 to 16 for eight temporaries. Opcodes are 0 multiply, 1 add, 2 subtract (a − b), 3 copy (a to dst). Executed in issue order, the arithmetic commands read only operand registers or temporaries written earlier in the same run.
- R3: With neither flag set, RZ ends as Pz·Qz·dx mod p, where dx = Qx·Pz² − Px·Qz².
- R4: With neither flag set, RX ends as dy² − dx³ − 2·(Px·Qz²·dx²), where dy = Qy·Pz³ − Py·Qz³.
- R5: With neither flag set, RY ends as (Px·Qz²·dx² − RX)·dy − Py·Qz³·dx³.
- R6: With the Pz flag latched, the 23 arithmetic commands are followed by three copy commands, and R ends equal to Q. The Pz flag takes priority over the Qz flag.
- R7: With only the Qz flag latched, the 23 arithmetic commands are followed by three copy commands, and R ends equal to P.
- R8: With no flag latched, exactly 23 commands are issued and none is a copy.
- R9: While cmd_valid is high and cmd_ready is low, the command fields hold steady. After a transfer, cmd_valid stays low until alu_done.
- R10: done is a single-cycle pulse in the cycle after the alu_done of the final command. A start pulse while busy is ignored.
- R11: After reset, cmd_valid, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an addition (ignored while busy) |
| pz_is_zero | input | 1 | Pz equals zero, sampled at start |
| qz_is_zero | input | 1 | Qz equals zero, sampled at start |
| cmd_valid | output | 1 | Command is presented |
| cmd_ready | input | 1 | Arithmetic unit accepts the command |
| cmd_op | output | 2 | Opcode |
| cmd_src_a | output | 5 | First source register |
| cmd_src_b | output | 5 | Second source register |
| cmd_dst | output | 5 | Destination register |
| alu_done | input | 1 | Accepted command has completed |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions check on every cycle that the command channel honours back-pressure, that only one command is outstanding at a time, that copies target only the result registers, that done lasts a single cycle, and that each run issues 23 or 26 commands to match the latched flags. Only the bench scenarios can show that the stream actually computes a correct sum. The bench executes every command on a modular register-file model and compares R with the addition formulas. It also shows that the infinity bypass picks the right operand, and that flag changes and start pulses in mid-run leave the result untouched.

// File: rtl/ptadd_pkg.sv
package ptadd_pkg;

  localparam int REG_ADDR_W  = 5;
  localparam int ARITH_STEPS = 23;
  localparam int COPY_STEPS  = 3;
  localparam int TOTAL_STEPS = ARITH_STEPS + COPY_STEPS;
  localparam int STEP_W      = $clog2(TOTAL_STEPS);

  typedef logic [REG_ADDR_W-1:0] raddr_t;

  localparam raddr_t A_PX = 5'd0;
  localparam raddr_t A_PY = 5'd1;
  localparam raddr_t A_PZ = 5'd2;
  localparam raddr_t A_QX = 5'd3;
  localparam raddr_t A_QY = 5'd4;
  localparam raddr_t A_QZ = 5'd5;
  localparam raddr_t A_RX = 5'd6;
  localparam raddr_t A_RY = 5'd7;
  localparam raddr_t A_RZ = 5'd8;
  localparam raddr_t A_T1 = 5'd9;
  localparam raddr_t A_T2 = 5'd10;
  localparam raddr_t A_T3 = 5'd11;
  localparam raddr_t A_T4 = 5'd12;
  localparam raddr_t A_T5 = 5'd13;
  localparam raddr_t A_T6 = 5'd14;
  localparam raddr_t A_T7 = 5'd15;
  localparam raddr_t A_T8 = 5'd16;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_COPY = 2'd3
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    raddr_t  a;
    raddr_t  b;
    raddr_t  dst;
  } uop_t;

  function automatic uop_t mk(alu_op_e op, raddr_t a, raddr_t b, raddr_t d);
    uop_t u;
    u.op = op; u.a = a; u.b = b; u.dst = d;
    return u;
  endfunction

  // Arithmetic list; temporaries are reused only after their last read.
  function automatic uop_t arith_uop(input logic [STEP_W-1:0] idx);
    case (idx)
      5'd0:    return mk(OP_MUL, A_PZ, A_PZ, A_T1);  // Pz^2
      5'd1:    return mk(OP_MUL, A_QZ, A_QZ, A_T2);  // Qz^2
      5'd2:    return mk(OP_MUL, A_PZ, A_T1, A_T3);  // Pz^3
      5'd3:    return mk(OP_MUL, A_QZ, A_T2, A_T4);  // Qz^3
      5'd4:    return mk(OP_MUL, A_PX, A_T2, A_T5);  // u1 = Px*Qz^2
      5'd5:    return mk(OP_MUL, A_QX, A_T1, A_T2);  // u2 = Qx*Pz^2
      5'd6:    return mk(OP_MUL, A_PY, A_T4, A_T6);  // s1 = Py*Qz^3
      5'd7:    return mk(OP_MUL, A_QY, A_T3, A_T4);  // s2 = Qy*Pz^3
      5'd8:    return mk(OP_SUB, A_T2, A_T5, A_T7);  // dx
      5'd9:    return mk(OP_SUB, A_T4, A_T6, A_T8);  // dy
      5'd10:   return mk(OP_MUL, A_PZ, A_QZ, A_T1);  // Pz*Qz
      5'd11:   return mk(OP_MUL, A_T7, A_T1, A_RZ);  // Rz
      5'd12:   return mk(OP_MUL, A_T8, A_T8, A_T2);  // dy^2
      5'd13:   return mk(OP_MUL, A_T7, A_T7, A_T3);  // dx^2
      5'd14:   return mk(OP_MUL, A_T7, A_T3, A_T4);  // dx^3
      5'd15:   return mk(OP_SUB, A_T2, A_T4, A_T1);  // dy^2 - dx^3
      5'd16:   return mk(OP_MUL, A_T5, A_T3, A_T2);  // u1*dx^2
      5'd17:   return mk(OP_ADD, A_T2, A_T2, A_T3);  // doubled term
      5'd18:   return mk(OP_SUB, A_T1, A_T3, A_RX);  // Rx
      5'd19:   return mk(OP_SUB, A_T2, A_RX, A_T1);
      5'd20:   return mk(OP_MUL, A_T1, A_T8, A_T2);
      5'd21:   return mk(OP_MUL, A_T6, A_T4, A_T3);  // s1*dx^3
      default: return mk(OP_SUB, A_T2, A_T3, A_RY);  // Ry
    endcase
  endfunction

endpackage

// File: rtl/ptadd_flag_latch.sv
module ptadd_flag_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic pz_zero,
  input  logic qz_zero,
  output logic take_q,
  output logic bypass
);
  logic pz_q, qz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pz_q <= 1'b0;
      qz_q <= 1'b0;
    end else if (capture) begin
      pz_q <= pz_zero;
      qz_q <= qz_zero;
    end
  end

  // Pz at infinity wins: result is Q; otherwise Qz at infinity gives P.
  assign take_q = pz_q;
  assign bypass = pz_q | qz_q;
endmodule

// File: rtl/ptadd_uop_rom.sv
module ptadd_uop_rom
  import ptadd_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  input  logic              take_q,
  output uop_t              uop
);
  localparam logic [STEP_W-1:0] FIRST_COPY = STEP_W'(ARITH_STEPS);

  logic [STEP_W-1:0] k;
  raddr_t            src_base;

  always_comb begin
    k        = step - FIRST_COPY;
    src_base = take_q ? A_QX : A_PX;
    if (step < FIRST_COPY) begin
      uop = arith_uop(step);
    end else begin
      uop = mk(OP_COPY, src_base + raddr_t'(k), '0, A_RX + raddr_t'(k));
    end
  end
endmodule

// File: rtl/ptadd_ctrl.sv
module ptadd_ctrl
  import ptadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bypass,
  input  logic              cmd_ready,
  input  logic              alu_done,
  output logic              capture,
  output logic [STEP_W-1:0] step,
  output logic              cmd_valid,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  localparam logic [STEP_W-1:0] LAST_ARITH = STEP_W'(ARITH_STEPS - 1);
  localparam logic [STEP_W-1:0] LAST_COPY  = STEP_W'(TOTAL_STEPS - 1);

  state_e            state;
  logic [STEP_W-1:0] last_step;

  assign last_step = bypass ? LAST_COPY : LAST_ARITH;
  assign capture   = (state == S_IDLE) && start;
  assign cmd_valid = (state == S_ISSUE);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          step  <= '0;
          state <= S_ISSUE;
        end
        S_ISSUE: if (cmd_ready) state <= S_WAIT;
        S_WAIT: if (alu_done) begin
          if (step == last_step) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            step  <= step + 1'b1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptadd_seq.sv
module ptadd_seq
  import ptadd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  pz_is_zero,
  input  logic                  qz_is_zero,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [1:0]            cmd_op,
  output logic [REG_ADDR_W-1:0] cmd_src_a,
  output logic [REG_ADDR_W-1:0] cmd_src_b,
  output logic [REG_ADDR_W-1:0] cmd_dst,
  input  logic                  alu_done,
  output logic                  busy,
  output logic                  done
);
  logic              capture;
  logic              take_q;
  logic              bypass;
  logic [STEP_W-1:0] step;
  uop_t              uop;

  ptadd_flag_latch u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .pz_zero (pz_is_zero),
    .qz_zero (qz_is_zero),
    .take_q  (take_q),
    .bypass  (bypass)
  );

  ptadd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bypass    (bypass),
    .cmd_ready (cmd_ready),
    .alu_done  (alu_done),
    .capture   (capture),
    .step      (step),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done)
  );

  ptadd_uop_rom u_rom (
    .step   (step),
    .take_q (take_q),
    .uop    (uop)
  );

  assign cmd_op    = uop.op;
  assign cmd_src_a = uop.a;
  assign cmd_src_b = uop.b;
  assign cmd_dst   = uop.dst;
endmodule

// File: rtl/ptadd_seq_chk.sv
module ptadd_seq_chk
  import ptadd_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [1:0]            cmd_op,
  input logic [REG_ADDR_W-1:0] cmd_src_a,
  input logic [REG_ADDR_W-1:0] cmd_src_b,
  input logic [REG_ADDR_W-1:0] cmd_dst,
  input logic                  busy,
  input logic                  done,
  input logic                  bypass
);
  logic [5:0] hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hs_cnt <= '0;
    else if (start && !busy)   hs_cnt <= '0;
    else if (cmd_valid && cmd_ready) hs_cnt <= hs_cnt + 1'b1;
  end

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
      $stable(cmd_src_a) && $stable(cmd_src_b) && $stable(cmd_dst)));

  p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  p_copy_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |-> (cmd_dst >= A_RX && cmd_dst <= A_RZ));

  p_cmd_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hs_cnt == (bypass ? 6'(TOTAL_STEPS) : 6'(ARITH_STEPS))));
endmodule

bind ptadd_seq ptadd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_src_a (cmd_src_a),
  .cmd_src_b (cmd_src_b),
  .cmd_dst   (cmd_dst),
  .busy      (busy),
  .done      (done),
  .bypass    (bypass)
);

// File: tb/test_ptadd_seq.sv
module test_ptadd_seq;
  localparam int AW = ptadd_pkg::REG_ADDR_W;
  localparam longint PR = 10007;
  localparam int NV = 6;
  // px, py, pz, qx, qy, qz
  localparam int VEC [NV][6] = '{
    '{1234, 5678,    91, 4321, 8765,  19},
    '{  17, 2000,     1, 3000,   45,   1},
    '{9999,    1, 10006,    2, 10005, 77},
    '{ 500,  600,     0,  700,  800, 900},
    '{ 111,  222,   333,  444,  555,   0},
    '{   5,    6,     7,    8,    9,  10}
  };

  logic clk = 0, rst_n = 0, start = 0, pz_is_zero = 0, qz_is_zero = 0;
  logic cmd_ready = 0, alu_done = 0;
  logic cmd_valid, busy, done;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_src_a, cmd_src_b, cmd_dst;

  int checks = 0, fails = 0, cyc = 0;
  longint rf [0:16];

  always #5 clk = ~clk;

  ptadd_seq i_ptadd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pz_is_zero(pz_is_zero),
    .qz_is_zero(qz_is_zero), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
    .cmd_dst(cmd_dst), .alu_done(alu_done), .busy(busy), .done(done)
  );

  function automatic longint md(longint x);
    return ((x % PR) + PR) % PR;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic exec_cmd(int op, int a, int b, int d);
    case (op)
      0: rf[d] = md(rf[a] * rf[b]);
      1: rf[d] = md(rf[a] + rf[b]);
      2: rf[d] = md(rf[a] - rf[b]);
      default: rf[d] = rf[a];
    endcase
  endtask

  task automatic run_vec(int v);
    longint px, py, pz, qx, qy, qz, u1, s1, dx, dy, dx2, dx3, ex, ey, ez;
    int ncmd = 0, ncopy = 0, lat, stall;
    bit fin = 0, zp, zq;
    logic [1:0] h_op; logic [AW-1:0] h_a, h_b, h_d;
    px = VEC[v][0]; py = VEC[v][1]; pz = VEC[v][2];
    qx = VEC[v][3]; qy = VEC[v][4]; qz = VEC[v][5];
    for (int i = 0; i < 17; i++) rf[i] = 0;
    rf[0] = px; rf[1] = py; rf[2] = pz; rf[3] = qx; rf[4] = qy; rf[5] = qz;
    zp = (pz == 0); zq = (qz == 0);
    pz_is_zero = zp; qz_is_zero = zq;
    start = 1;
    @(negedge clk);
    start = 0;
    pz_is_zero = !zp; qz_is_zero = !zq;  // R1: late flag changes must not matter
    while (!fin && ncmd < 40) begin
      chk("R9 valid presented", cmd_valid, 1);
      h_op = cmd_op; h_a = cmd_src_a; h_b = cmd_src_b; h_d = cmd_dst;
      stall = ncmd % 3;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        if (cmd_valid !== 1'b1 || cmd_op !== h_op || cmd_src_a !== h_a ||
            cmd_src_b !== h_b || cmd_dst !== h_d)
          chk("R9 hold under back-pressure", {cmd_valid, cmd_op, cmd_dst}, {1'b1, h_op, h_d});
      end
      cmd_ready = 1;
      @(negedge clk);
      cmd_ready = 0;
      exec_cmd(int'(h_op), int'(h_a), int'(h_b), int'(h_d));
      if (h_op == 2'd3) ncopy++;
      ncmd++;
      lat = 1 + (ncmd % 2);
      for (int l = 0; l < lat; l++) begin
        if (cmd_valid !== 1'b0) chk("R9 wait for completion", cmd_valid, 0);
        if (ncmd == 5 && l == 0) start = 1;  // R10: start while busy
        @(negedge clk);
        start = 0;
      end
      alu_done = 1;
      @(negedge clk);
      alu_done = 0;
      if (done === 1'b1) fin = 1;
    end
    chk("R10 done seen", fin, 1);
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
    chk("R10 idle after run", busy, 0);
    if (zp) begin
      chk("R6 command count", ncmd, 26); chk("R6 copies", ncopy, 3);
      chk("R6 RX=QX", rf[6], qx); chk("R6 RY=QY", rf[7], qy); chk("R6 RZ=QZ", rf[8], qz);
    end else if (zq) begin
      chk("R7 command count", ncmd, 26); chk("R7 copies", ncopy, 3);
      chk("R7 RX=PX", rf[6], px); chk("R7 RY=PY", rf[7], py); chk("R7 RZ=PZ", rf[8], pz);
    end else begin
      u1 = md(px * md(qz * qz));
      s1 = md(py * md(md(qz * qz) * qz));
      dx = md(md(qx * md(pz * pz)) - u1);
      dy = md(md(qy * md(md(pz * pz) * pz)) - s1);
      dx2 = md(dx * dx); dx3 = md(dx2 * dx);
      ez = md(md(pz * qz) * dx);
      ex = md(md(dy * dy) - dx3 - 2 * md(u1 * dx2));
      ey = md(md(md(u1 * dx2) - ex) * dy - md(s1 * dx3));
      chk("R8 command count", ncmd, 23); chk("R8 no copies", ncopy, 0);
      chk("R3 RZ", rf[8], ez);
      chk("R4 RX", rf[6], ex);
      chk("R5 RY", rf[7], ey);
      chk("R2 operands untouched", rf[0] + rf[1] + rf[2], px + py + pz);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 cmd_valid in reset", cmd_valid, 0);
    chk("R11 busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 done after reset", done, 0);
    chk("R11 cmd_valid after reset", cmd_valid, 0);
    for (int v = 0; v < NV; v++) run_vec(v);
    // R6 priority: both flags asserted picks Q
    pz_is_zero = 1; qz_is_zero = 1;
    start = 1; @(negedge clk); start = 0;
    for (int n = 0; n < 26; n++) begin
      while (cmd_valid !== 1'b1 && cyc < 100000) @(negedge clk);
      if (n >= 23) chk("R6 priority copy source", cmd_src_a, AW'(3 + n - 23));
      cmd_ready = 1; @(negedge clk); cmd_ready = 0;
      alu_done = 1; @(negedge clk); alu_done = 0;
    end
    chk("R10 done after priority run", done, 1);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule